// File: doc/BRIEF.md
# Sized Shift and Rotate Unit

This unit carries out the seven shift and rotate operations of an integer datapath on a 64-bit source, at an operand size of 1, 2, 4 or 8 bytes. The seven operations are logical left, logical right, arithmetic right, plain rotate left and right, and rotate left and right through the carry bit. The count comes either from a register operand or from an 8-bit immediate. Before use it is reduced to the bits that the operand size allows. The two through-carry rotates bring the current carry flag into the ring, so they rotate over the operand width plus one bit.

The computed value is written only into the low bytes that the operand size covers. The bytes above keep the old destination value. A rotate whose effective count is zero returns the old destination untouched. The shift, rotate and merge logic is purely combinational. A single output register stage holds the merged value and the carry flag, which passes through unchanged, and raises a valid strobe one cycle after each accepted request. Flag generation from the result is left to a neighbouring unit.

Top module: `shift_rotate_unit`

## Requirements
- R1: The count is the selected count operand (`cnt_reg`, or `cnt_imm` zero-extended when `cnt_is_imm` is 1), reduced to its low 6 bits for size code 3 (8 bytes) and to its low 5 bits for size codes 0, 1 and 2 (1, 2 and 4 bytes).
- R2: Op code 0 (logical left) moves the source left by the count and fills with zeros; bits shifted past the operand width are lost; a count of zero returns the source.
- R3: Op code 1 (logical right) moves the operand-width source right by the count and fills with zeros, so no source bit above the operand width reaches the result.
- R4: Op code 2 (arithmetic right) moves the operand-width source right by the count and copies the operand's top bit into every vacated position within the width.
- R5: Op codes 3 (rotate left) and 4 (rotate right) rotate within the operand width by the count taken modulo the width, so bits leaving one end enter at the other.
- R6: Op code 5 (rotate left through carry) rotates the width+1-bit ring {operand, CF} left by the count: the old CF lands at bit count-1 and the top count-1 operand bits fill the positions below it; counts from 1 to the width are supported.
- R7: Op code 6 (rotate right through carry) rotates the ring right by the count: the old CF lands at bit width-count and the low count-1 operand bits sit above it; counts from 1 to the width are supported.
- R8: A rotate (op codes 3 to 6) whose effective count is zero, and op code 7 for any count, return the old destination exactly.
- R9: The computed value replaces only the low 8, 16, 32 or 64 bits (size codes 0 to 3) of the old destination; the bits above are taken from the old destination.
- R10: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high; `dst_out` and `cf_out` (the `cf_in` of that request) change only then and hold otherwise.
- R11: During and just after reset, `out_valid`, `dst_out` and `cf_out` are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request present this cycle |
| op_code | input | 3 | Operation select, codes 0 to 7 as in the requirements |
| size_code | input | 2 | Operand size: 0=1, 1=2, 2=4, 3=8 bytes |
| src_val | input | 64 | Value to shift or rotate |
| old_dst | input | 64 | Previous destination value to merge into |
| cnt_reg | input | 64 | Count taken from a register |
| cnt_imm | input | 8 | Count taken from an immediate |
| cnt_is_imm | input | 1 | 1 selects the immediate count |
| cf_in | input | 1 | Current carry flag |
| out_valid | output | 1 | Result registered this cycle |
| dst_out | output | 64 | Merged destination value |
| cf_out | output | 1 | Carry flag passed through with the result |

## Verification
The properties assume that `in_valid`, `op_code`, `size_code` and the count inputs are known at every sampled edge after reset. The properties on data cover only cases that hold for any count: the size merge, the hold opcode and an immediate count of zero. The through-carry rotates are defined only for counts up to the operand width. The random stimulus therefore draws those counts from 0 to the width and lets every other operation use the full masked count range. Idle gaps of random length test that outputs hold between requests.

// File: rtl/sru_pkg.sv
package sru_pkg;

    localparam int OP_W   = 3;
    localparam int SIZE_W = 2;

    typedef enum logic [OP_W-1:0] {
        OP_SHL  = 3'd0,
        OP_SHR  = 3'd1,
        OP_SAR  = 3'd2,
        OP_ROL  = 3'd3,
        OP_ROR  = 3'd4,
        OP_RCL  = 3'd5,
        OP_RCR  = 3'd6,
        OP_HOLD = 3'd7
    } sru_op_e;

    typedef enum logic [SIZE_W-1:0] {
        SZ_B1 = 2'd0,
        SZ_B2 = 2'd1,
        SZ_B4 = 2'd2,
        SZ_B8 = 2'd3
    } sru_size_e;

endpackage

// File: rtl/sru_count.sv
module sru_count
    import sru_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8,
    parameter int CNT_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] cnt_reg,
    input  logic [IMM_W-1:0]  cnt_imm,
    input  logic              cnt_is_imm,
    input  sru_size_e         size_sel,
    output logic [CNT_W-1:0]  cnt_eff
);

    logic [DATA_W-1:0] cnt_sel;

    always_comb begin
        cnt_sel = cnt_is_imm ? {{(DATA_W-IMM_W){1'b0}}, cnt_imm} : cnt_reg;
        // full-width operands allow one more count bit (R1)
        if (size_sel == SZ_B8) begin
            cnt_eff = cnt_sel[CNT_W-1:0];
        end else begin
            cnt_eff = {1'b0, cnt_sel[CNT_W-2:0]};
        end
    end

endmodule

// File: rtl/sru_width.sv
module sru_width
    import sru_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int WID_W  = $clog2(DATA_W) + 1
) (
    input  sru_size_e         size_sel,
    output logic [WID_W-1:0]  width,
    output logic [DATA_W-1:0] wmask
);

    assign width = WID_W'(8) << size_sel;

    for (genvar gi = 0; gi < DATA_W; gi++) begin : g_mask
        assign wmask[gi] = (WID_W'(gi) < width);
    end

endmodule

// File: rtl/sru_core.sv
module sru_core
    import sru_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int CNT_W  = $clog2(DATA_W),
    parameter int WID_W  = CNT_W + 1
) (
    input  sru_op_e           op_sel,
    input  logic [DATA_W-1:0] src_val,
    input  logic [CNT_W-1:0]  cnt_eff,
    input  logic [WID_W-1:0]  width,
    input  logic [DATA_W-1:0] wmask,
    input  logic              cf_in,
    output logic [DATA_W-1:0] raw_res,
    output logic              keep_old
);

    logic [DATA_W-1:0]        opnd;
    logic [DATA_W-1:0]        cf_vec;
    logic                     sign_bit;
    logic signed [DATA_W-1:0] sext;
    logic [WID_W-1:0]         n;
    logic [WID_W-1:0]         n_rot;
    logic [DATA_W-1:0]        shl_v, shr_v, sar_v, rol_v, ror_v, rcl_v, rcr_v;

    always_comb begin
        opnd     = src_val & wmask;
        cf_vec   = {{(DATA_W-1){1'b0}}, cf_in};
        sign_bit = src_val[CNT_W'(width - WID_W'(1))];
        sext     = sign_bit ? (src_val | ~wmask) : opnd;
        n        = {1'b0, cnt_eff};
        // width is a power of two: modulo is a mask
        n_rot    = n & (width - WID_W'(1));

        shl_v = opnd << n;
        shr_v = opnd >> n;
        sar_v = sext >>> n;
        rol_v = (opnd << n_rot) | (opnd >> (width - n_rot));
        ror_v = (opnd >> n_rot) | (opnd << (width - n_rot));

        rcl_v = (opnd << n) | (cf_vec << (n - WID_W'(1)));
        if (n > WID_W'(1)) begin
            rcl_v = rcl_v | (opnd >> (width + WID_W'(1) - n));
        end

        rcr_v = (opnd >> n) | (cf_vec << (width - n));
        if (n > WID_W'(1)) begin
            rcr_v = rcr_v | (opnd << (width + WID_W'(1) - n));
        end

        raw_res  = '0;
        keep_old = 1'b0;
        unique case (op_sel)
            OP_SHL:  raw_res = shl_v;
            OP_SHR:  raw_res = shr_v;
            OP_SAR:  raw_res = sar_v;
            OP_ROL: begin
                raw_res  = rol_v;
                keep_old = (n_rot == '0);
            end
            OP_ROR: begin
                raw_res  = ror_v;
                keep_old = (n_rot == '0);
            end
            OP_RCL: begin
                raw_res  = rcl_v;
                keep_old = (n == '0);
            end
            OP_RCR: begin
                raw_res  = rcr_v;
                keep_old = (n == '0);
            end
            OP_HOLD: keep_old = 1'b1;
            default: keep_old = 1'b1;
        endcase
    end

endmodule

// File: rtl/sru_merge.sv
module sru_merge #(
    parameter int DATA_W = 64
) (
    input  logic [DATA_W-1:0] old_dst,
    input  logic [DATA_W-1:0] raw_res,
    input  logic [DATA_W-1:0] wmask,
    input  logic              keep_old,
    output logic [DATA_W-1:0] merged
);

    always_comb begin
        if (keep_old) begin
            merged = old_dst;
        end else begin
            merged = (old_dst & ~wmask) | (raw_res & wmask);
        end
    end

endmodule

// File: rtl/shift_rotate_unit.sv
module shift_rotate_unit
    import sru_pkg::*;
#(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [2:0]        op_code,
    input  logic [1:0]        size_code,
    input  logic [DATA_W-1:0] src_val,
    input  logic [DATA_W-1:0] old_dst,
    input  logic [DATA_W-1:0] cnt_reg,
    input  logic [IMM_W-1:0]  cnt_imm,
    input  logic              cnt_is_imm,
    input  logic              cf_in,
    output logic              out_valid,
    output logic [DATA_W-1:0] dst_out,
    output logic              cf_out
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam int WID_W = CNT_W + 1;

    typedef struct packed {
        logic              valid;
        logic [DATA_W-1:0] dst;
        logic              cf;
    } stage_t;

    stage_t stage_d, stage_q;

    sru_op_e           op_sel;
    sru_size_e         size_sel;
    logic [CNT_W-1:0]  cnt_eff;
    logic [WID_W-1:0]  width;
    logic [DATA_W-1:0] wmask;
    logic [DATA_W-1:0] raw_res;
    logic              keep_old;
    logic [DATA_W-1:0] merged;

    assign op_sel   = sru_op_e'(op_code);
    assign size_sel = sru_size_e'(size_code);

    sru_count #(.DATA_W(DATA_W), .IMM_W(IMM_W), .CNT_W(CNT_W)) u_count (
        .cnt_reg    (cnt_reg),
        .cnt_imm    (cnt_imm),
        .cnt_is_imm (cnt_is_imm),
        .size_sel   (size_sel),
        .cnt_eff    (cnt_eff)
    );

    sru_width #(.DATA_W(DATA_W), .WID_W(WID_W)) u_width (
        .size_sel (size_sel),
        .width    (width),
        .wmask    (wmask)
    );

    sru_core #(.DATA_W(DATA_W), .CNT_W(CNT_W), .WID_W(WID_W)) u_core (
        .op_sel   (op_sel),
        .src_val  (src_val),
        .cnt_eff  (cnt_eff),
        .width    (width),
        .wmask    (wmask),
        .cf_in    (cf_in),
        .raw_res  (raw_res),
        .keep_old (keep_old)
    );

    sru_merge #(.DATA_W(DATA_W)) u_merge (
        .old_dst  (old_dst),
        .raw_res  (raw_res),
        .wmask    (wmask),
        .keep_old (keep_old),
        .merged   (merged)
    );

    always_comb begin
        stage_d       = stage_q;
        stage_d.valid = in_valid;
        if (in_valid) begin
            stage_d.dst = merged;
            stage_d.cf  = cf_in;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '0;
        end else begin
            stage_q <= stage_d;
        end
    end

    assign out_valid = stage_q.valid;
    assign dst_out   = stage_q.dst;
    assign cf_out    = stage_q.cf;

endmodule

// File: rtl/sru_checker.sv
module sru_checker #(
    parameter int DATA_W = 64,
    parameter int IMM_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic [2:0]        op_code,
    input logic [1:0]        size_code,
    input logic [DATA_W-1:0] old_dst,
    input logic [IMM_W-1:0]  cnt_imm,
    input logic              cnt_is_imm,
    input logic              cf_in,
    input logic              out_valid,
    input logic [DATA_W-1:0] dst_out,
    input logic              cf_out
);

    // R10
    valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R10
    valid_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    // R10
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(dst_out) && $stable(cf_out)));

    // R10
    carry_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (cf_out == $past(cf_in)));

    // R8
    hold_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code == 3'd7) |=> (dst_out == $past(old_dst)));

    // R8
    zero_rot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_code >= 3'd3 && cnt_is_imm && cnt_imm == '0)
        |=> (dst_out == $past(old_dst)));

    // R9
    byte_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code == 2'd0)
        |=> (dst_out[DATA_W-1:8] == $past(old_dst[DATA_W-1:8])));

    // R9
    half_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && size_code == 2'd1)
        |=> (dst_out[DATA_W-1:16] == $past(old_dst[DATA_W-1:16])));

endmodule

bind shift_rotate_unit sru_checker #(.DATA_W(DATA_W), .IMM_W(IMM_W)) u_sru_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_code    (op_code),
    .size_code  (size_code),
    .old_dst    (old_dst),
    .cnt_imm    (cnt_imm),
    .cnt_is_imm (cnt_is_imm),
    .cf_in      (cf_in),
    .out_valid  (out_valid),
    .dst_out    (dst_out),
    .cf_out     (cf_out)
);

// File: tb/test_shift_rotate_unit.sv
module test_shift_rotate_unit;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  op_code;
    logic [1:0]  size_code;
    logic [63:0] src_val;
    logic [63:0] old_dst;
    logic [63:0] cnt_reg;
    logic [7:0]  cnt_imm;
    logic        cnt_is_imm;
    logic        cf_in;
    logic        out_valid;
    logic [63:0] dst_out;
    logic        cf_out;

    int checks   = 0;
    int failures = 0;
    int cycles   = 0;
    bit done     = 1'b0;

    logic        exp_valid;
    logic [63:0] exp_dst;
    logic        exp_cf;
    logic [2:0]  exp_op;

    always #4 clk = ~clk;

    shift_rotate_unit i_shift_rotate_unit (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .op_code    (op_code),
        .size_code  (size_code),
        .src_val    (src_val),
        .old_dst    (old_dst),
        .cnt_reg    (cnt_reg),
        .cnt_imm    (cnt_imm),
        .cnt_is_imm (cnt_is_imm),
        .cf_in      (cf_in),
        .out_valid  (out_valid),
        .dst_out    (dst_out),
        .cf_out     (cf_out)
    );

    function automatic string tag_of(input logic [2:0] op);
        case (op)
            3'd0: return "R2";
            3'd1: return "R3";
            3'd2: return "R4";
            3'd3, 3'd4: return "R5";
            3'd5: return "R6";
            3'd6: return "R7";
            default: return "R8";
        endcase
    endfunction

    // Bit-at-a-time reference: one step of the shift or rotate per count unit.
    function automatic logic [63:0] model(input logic [2:0] op, input logic [1:0] sz,
                                          input logic [63:0] src, input logic [63:0] old,
                                          input logic [63:0] craw, input logic cf);
        int w = 8 << sz;
        int n = (sz == 2'd3) ? int'(craw[5:0]) : int'(craw[4:0]);
        logic [63:0] wm = '0;
        logic [63:0] r;
        logic c = cf;
        logic b;
        logic sgn;
        for (int k = 0; k < w; k++) wm[k] = 1'b1;
        r   = src & wm;
        sgn = src[w-1];
        if (op == 3'd7) return old;
        if ((op == 3'd3 || op == 3'd4) && (n % w) == 0) return old;
        if ((op == 3'd5 || op == 3'd6) && n == 0) return old;
        for (int k = 0; k < n; k++) begin
            case (op)
                3'd0: r = (r << 1) & wm;
                3'd1: r = r >> 1;
                3'd2: begin r = r >> 1; r[w-1] = sgn; end
                3'd3: begin b = r[w-1]; r = ((r << 1) & wm); r[0] = b; end
                3'd4: begin b = r[0]; r = r >> 1; r[w-1] = b; end
                3'd5: begin b = r[w-1]; r = ((r << 1) & wm); r[0] = c; c = b; end
                default: begin b = r[0]; r = r >> 1; r[w-1] = c; c = b; end
            endcase
        end
        return (old & ~wm) | (r & wm);
    endfunction

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Drive at a falling edge, then compare at the next falling edge.
    task automatic step(input bit iv, input logic [2:0] op, input logic [1:0] sz,
                        input logic [63:0] src, input logic [63:0] old,
                        input logic [63:0] creg, input logic [7:0] cimm,
                        input bit use_imm, input logic cf);
        logic [63:0] craw;
        in_valid   = iv;
        op_code    = op;
        size_code  = sz;
        src_val    = src;
        old_dst    = old;
        cnt_reg    = creg;
        cnt_imm    = cimm;
        cnt_is_imm = use_imm;
        cf_in      = cf;
        craw = use_imm ? {56'd0, cimm} : creg;
        exp_valid = iv;
        if (iv) begin
            exp_dst = model(op, sz, src, old, craw, cf);
            exp_cf  = cf;
            exp_op  = op;
        end
        @(negedge clk);
        chk(out_valid == exp_valid, "R10 valid", {63'd0, out_valid}, {63'd0, exp_valid});
        chk(cf_out == exp_cf, "R10 carry", {63'd0, cf_out}, {63'd0, exp_cf});
        if (iv) chk(dst_out == exp_dst, tag_of(exp_op), dst_out, exp_dst);
        else    chk(dst_out == exp_dst, "R10 hold", dst_out, exp_dst);
    endtask

    initial begin
        rst_n = 1'b0;
        in_valid = 1'b0; op_code = '0; size_code = '0; src_val = '0; old_dst = '0;
        cnt_reg = '0; cnt_imm = '0; cnt_is_imm = 1'b0; cf_in = 1'b0;
        exp_valid = 1'b0; exp_dst = '0; exp_cf = 1'b0; exp_op = '0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R11", {63'd0, out_valid}, 64'd0);
        chk(dst_out == 64'd0, "R11", dst_out, 64'd0);
        chk(cf_out == 1'b0, "R11", {63'd0, cf_out}, 64'd0);
        rst_n = 1'b1;

        // R1: count 0x21 at byte size keeps 5 bits -> 1
        step(1, 3'd0, 2'd0, 64'h1, 64'hFFFF_FFFF_FFFF_FF00, 64'h21, 8'h0, 0, 0);
        chk(dst_out == 64'hFFFF_FFFF_FFFF_FF02, "R1", dst_out, 64'hFFFF_FFFF_FFFF_FF02);
        // R1: count 0x41 at 8 bytes keeps 6 bits -> 1; immediate path
        step(1, 3'd0, 2'd3, 64'h1, 64'h0, 64'h0, 8'h41, 1, 0);
        chk(dst_out == 64'h2, "R1", dst_out, 64'h2);
        // R1: count 0x20 at 4 bytes masks to 0, shift returns source
        step(1, 3'd0, 2'd2, 64'hAAAA_AAAA_1234_5678, 64'h0, 64'h20, 8'h0, 0, 1);
        chk(dst_out == 64'h1234_5678, "R1", dst_out, 64'h1234_5678);
        // R3: upper source bits do not leak in
        step(1, 3'd1, 2'd0, 64'hFFFF_FFFF_FFFF_FF80, 64'h0, 64'd4, 8'h0, 0, 0);
        chk(dst_out == 64'h08, "R3", dst_out, 64'h08);
        // R4: sign fill within 16 bits
        step(1, 3'd2, 2'd1, 64'h8000, 64'h0, 64'd4, 8'h0, 0, 0);
        chk(dst_out == 64'hF800, "R4", dst_out, 64'hF800);
        // R5: rotate left by 9 at byte size acts as 1
        step(1, 3'd3, 2'd0, 64'h81, 64'h0, 64'd9, 8'h0, 0, 0);
        chk(dst_out == 64'h03, "R5", dst_out, 64'h03);
        // R6: top bit leaves, old CF 0 enters at bit 0
        step(1, 3'd5, 2'd0, 64'h80, 64'h0, 64'd1, 8'h0, 0, 0);
        chk(dst_out == 64'h00, "R6", dst_out, 64'h00);
        // R7: old CF lands at bit width-1
        step(1, 3'd6, 2'd0, 64'h01, 64'h0, 64'd1, 8'h0, 0, 1);
        chk(dst_out == 64'h80, "R7", dst_out, 64'h80);
        // R8: zero-count rotate leaves destination
        step(1, 3'd4, 2'd2, 64'h5555, 64'hDEAD_BEEF_0000_1234, 64'd32, 8'h0, 0, 0);
        chk(dst_out == 64'hDEAD_BEEF_0000_1234, "R8", dst_out, 64'hDEAD_BEEF_0000_1234);
        // R9: 32-bit merge keeps upper half
        step(1, 3'd0, 2'd2, 64'h1, 64'hCAFE_F00D_FFFF_FFFF, 64'd31, 8'h0, 0, 0);
        chk(dst_out == 64'hCAFE_F00D_8000_0000, "R9", dst_out, 64'hCAFE_F00D_8000_0000);
        // R10: idle cycle holds
        step(0, 3'd0, 2'd0, 64'h0, 64'h0, 64'h0, 8'h0, 0, 1);

        for (int i = 0; i < 4000; i++) begin
            logic [2:0]  op  = 3'($urandom_range(0, 7));
            logic [1:0]  sz  = 2'($urandom_range(0, 3));
            int          w   = 8 << sz;
            logic [63:0] cr  = {$urandom, $urandom};
            logic [7:0]  ci  = 8'($urandom);
            bit          ui  = 1'($urandom);
            if (op == 3'd5 || op == 3'd6) begin
                cr = 64'($urandom_range(0, w));
                ci = 8'(cr);
            end
            step(($urandom_range(0, 3) != 0), op, sz, {$urandom, $urandom},
                 {$urandom, $urandom}, cr, ci, ui, 1'($urandom));
        end
        finish_run();
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
            finish_run();
        end
    end

endmodule